// File: doc/BRIEF.md
# Double-Buffered Serial Peripheral Port (Master/Slave)

This block is a synchronous serial port that runs either as the bus master, making its own shift clock, or as a slave clocked from outside and gated by an active-low select. One 16-bit shift register moves a word out on the data-out pin while it takes a word in from the data-in pin. A word is 8 or 16 bits, chosen by a control bit.

The processor side has one buffer address for both directions. A write fills a transmit holding register, and a read returns a receive holding register, so the next word can be queued while the current one is still shifting. A completed word lands in the receive register and raises an interrupt flag, which reaches the interrupt pin only when its enable is set. If the receive register is still unread when a new word completes, the new word is dropped and a sticky overflow flag freezes the shift engine until the processor reads.

In master mode the shift clock comes from the system clock through two cascaded dividers: a coarse one (1, 4, 16 or 64) and a fine one (1 to 8).

Top module: `spi_dbuf_port`

## Requirements
- R1: After reset all status outputs (rx full, tx full, overflow, busy, interrupt flag, interrupt) are 0, `sck_o` is 0, and the port is a slave with `sdo_oe` following the select input.
- R2: Control bit 1 picks a 16-bit word (1) or an 8-bit word (0). Bits go MSB first: the low 8 bits of the transmit word in 8-bit mode, the whole word in 16-bit mode. A received 8-bit word appears in bits 7:0 with bits 15:8 zero.
- R3: When a word completes it is copied to the receive register, `st_rx_full` is set and `irq_flag` is set. `irq` equals `irq_flag` AND control bit 7. A `flag_clr` pulse clears `irq_flag`.
- R4: If a word completes while `st_rx_full` is 1 and no read happens in the same cycle, `st_ovf` is set, the new word is discarded and `buf_rdata` keeps the old word.
- R5: While `st_ovf` is 1, every shift clock edge is ignored and no master transfer starts, so no word completes.
- R6: `buf_rdata` always shows the receive register. A `buf_rd` pulse clears `st_rx_full` and `st_ovf`.
- R7: A `buf_wr` pulse loads the transmit register and sets `st_tx_full`. Its data moves to the shift register when the engine is idle, or at the completion of a word (preload). That move clears `st_tx_full`.
- R8: Master mode is control bit 0 = 1. In master mode `sck_oe` is 1, the clock idles low, and the `sck_o` period is 2·P·S system clocks, where P = 4^(control bits 3:2) and S = (control bits 6:4) + 1.
- R9: A master transfer starts only when the shift engine is idle and holds freshly loaded transmit data.
- R10: In slave mode `sck_i` clocks the engine while `ss_n` is 0: `sdo` changes on the rising edge and `sdi` is sampled on the falling edge. `sdo_oe` is 1 only while `ss_n` is low.
- R11: In slave mode, raising `ss_n` in the middle of a word resets the bit counter and turns off `sdo_oe`. The partial word never completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control value: b0 master, b1 wide, b3:2 coarse divide, b6:4 fine divide-1, b7 irq enable |
| buf_wr | input | 1 | Buffer write strobe (transmit register) |
| buf_wdata | input | 16 | Buffer write data |
| buf_rd | input | 1 | Buffer read strobe (clears rx full and overflow) |
| buf_rdata | output | 16 | Receive register contents |
| flag_clr | input | 1 | Clears the interrupt flag |
| st_rx_full | output | 1 | Receive register holds unread data |
| st_tx_full | output | 1 | Transmit register holds data not yet moved |
| st_ovf | output | 1 | Sticky receive overflow |
| st_busy | output | 1 | A word is in progress |
| irq_flag | output | 1 | Word-complete flag |
| irq | output | 1 | Flag gated by enable |
| sck_i | input | 1 | Shift clock in (slave) |
| sck_o | output | 1 | Shift clock out (master) |
| sck_oe | output | 1 | Shift clock output enable |
| ss_n | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data out enable |

## Verification
The bench sweeps all 32 master divider settings. For each one it measures the `sck_o` rise-to-rise spacing and checks it against 2·P·S, so a divider that counts one too many or picks the wrong coarse ratio shows up as a wrong period. It queues a second word while the first is shifting and checks that the first is received intact and the second follows it. A design that preloaded too early would corrupt the word in flight, and one that never preloaded would stall. It drives overflow in both modes and then applies clock edges. A port that kept shifting, overwrote the held word, or raised the flag again would be caught there. It also aborts a slave word half way, and a counter that was not reset would misalign the next full byte.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
   localparam int unsigned PRI_MAX = 64;
   localparam int unsigned SEC_MAX = 8;
   localparam int unsigned SEC_W   = $clog2(SEC_MAX);

   // control word layout: b7 ie, b6:4 fine-1, b3:2 coarse select, b1 wide, b0 master
   typedef struct packed {
      logic             ie;
      logic [SEC_W-1:0] sec_m1;
      logic [1:0]       pri_sel;
      logic             wide;
      logic             master;
   } spi_cfg_t;

   function automatic int unsigned pri_ratio(input logic [1:0] sel);
      return 32'd1 << (2 * sel);
   endfunction
endpackage

// File: rtl/spi_dbuf_sync.sv
module spi_dbuf_sync #(
   parameter int unsigned N       = 2,
   parameter int unsigned STAGES  = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] dout
);
   initial assert (STAGES >= 1) else $error("spi_dbuf_sync: STAGES must be >= 1");

   generate
      if (STAGES == 1) begin : g_single
         logic [N-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= din;
         end
         assign dout = q;
      end else begin : g_chain
         logic [STAGES-1:0][N-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= {STAGES{RST_VAL}};
            else        q <= {q[STAGES-2:0], din};
         end
         assign dout = q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_dbuf_clkgen.sv
module spi_dbuf_clkgen
   import spi_dbuf_pkg::*;
#(
   parameter int unsigned PMAX = PRI_MAX,
   parameter int unsigned SMAX = SEC_MAX
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   input  logic [1:0]               pri_sel,
   input  logic [$clog2(SMAX)-1:0]  sec_m1,
   output logic                     tick
);
   localparam int unsigned PW = $clog2(PMAX);
   localparam int unsigned SW = $clog2(SMAX);

   initial assert ((1 << PW) == PMAX && PMAX >= 64)
      else $error("spi_dbuf_clkgen: PMAX must be a power of two >= 64");
   initial assert ((1 << SW) == SMAX)
      else $error("spi_dbuf_clkgen: SMAX must be a power of two");

   logic [PW-1:0] pcnt;
   logic [SW-1:0] scnt;
   logic [PW-1:0] pri_lim;
   logic          pri_hit, sec_hit;

   assign pri_lim = PW'(pri_ratio(pri_sel) - 1);
   assign pri_hit = (pcnt == pri_lim);
   assign sec_hit = (scnt == sec_m1);
   assign tick    = en & pri_hit & sec_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
         scnt <= '0;
      end else if (!en) begin
         pcnt <= '0;
         scnt <= '0;
      end else begin
         pcnt <= pri_hit ? '0 : pcnt + 1'b1;
         if (pri_hit) scnt <= sec_hit ? '0 : scnt + 1'b1;
      end
   end

   // R8: the fine stage never passes its limit while running
   a_r8_sec_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $stable(sec_m1)) |-> scnt <= sec_m1);
endmodule

// File: rtl/spi_dbuf_shift.sv
module spi_dbuf_shift #(
   parameter int unsigned W  = 16,
   parameter int unsigned NW = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wide,
   input  logic                 load,
   input  logic [W-1:0]         load_val,
   input  logic                 rise,
   input  logic                 fall,
   input  logic                 clr,
   input  logic                 sdi,
   output logic                 obit,
   output logic                 done,
   output logic [W-1:0]         word,
   output logic [$clog2(W)-1:0] cnt_o
);
   localparam int unsigned CW = $clog2(W);
   localparam logic [CW-1:0] LAST_W = CW'(W - 1);
   localparam logic [CW-1:0] LAST_N = CW'(NW - 1);

   initial assert (NW < W && NW >= 2) else $error("spi_dbuf_shift: need 2 <= NW < W");

   logic [W-1:0]  sr, nxt;
   logic [CW-1:0] cnt;

   assign nxt   = {sr[W-2:0], sdi};
   assign done  = fall & (cnt == (wide ? LAST_W : LAST_N));
   assign word  = wide ? nxt : {{(W-NW){1'b0}}, nxt[NW-1:0]};
   assign cnt_o = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         cnt  <= '0;
         obit <= 1'b0;
      end else begin
         if (load)      sr <= load_val;
         else if (fall) sr <= nxt;
         if (clr)       cnt <= '0;
         else if (fall) cnt <= done ? '0 : cnt + 1'b1;
         if (rise)      obit <= wide ? sr[W-1] : sr[NW-1];
      end
   end

   // R2: a word ends with the counter back at zero
   a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> cnt == '0);
endmodule

// File: rtl/spi_dbuf_port.sv
module spi_dbuf_port
   import spi_dbuf_pkg::*;
#(
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned NARROW_W    = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [7:0]        cfg_wdata,
   input  logic              buf_wr,
   input  logic [WORD_W-1:0] buf_wdata,
   input  logic              buf_rd,
   output logic [WORD_W-1:0] buf_rdata,
   input  logic              flag_clr,
   output logic              st_rx_full,
   output logic              st_tx_full,
   output logic              st_ovf,
   output logic              st_busy,
   output logic              irq_flag,
   output logic              irq,
   input  logic              sck_i,
   output logic              sck_o,
   output logic              sck_oe,
   input  logic              ss_n,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_oe
);
   localparam int unsigned CW = $clog2(WORD_W);

   initial assert ($bits(spi_cfg_t) == 8) else $error("spi_dbuf_port: control word must be 8 bits");

   spi_cfg_t          cfg_q;
   logic [WORD_W-1:0] txbuf_q, rxbuf_q, word;
   logic              tx_full_q, rx_full_q, ovf_q, flag_q, active_q, armed_q, sck_q, sck_d;
   logic              sck_s, ss_s, ss_act, s_rise, s_fall, m_tick;
   logic              rise, fall, clr, done, start, load, rd_full, obit;
   logic [CW-1:0]     bit_cnt;

   spi_dbuf_sync #(.N(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
      .clk(clk), .rst_n(rst_n), .din({sck_i, ss_n}), .dout({sck_s, ss_s}));

   spi_dbuf_clkgen u_clk (
      .clk(clk), .rst_n(rst_n), .en(cfg_q.master & active_q & ~ovf_q),
      .pri_sel(cfg_q.pri_sel), .sec_m1(cfg_q.sec_m1), .tick(m_tick));

   spi_dbuf_shift #(.W(WORD_W), .NW(NARROW_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .wide(cfg_q.wide), .load(load), .load_val(txbuf_q),
      .rise(rise), .fall(fall), .clr(clr), .sdi(sdi), .obit(obit), .done(done),
      .word(word), .cnt_o(bit_cnt));

   assign ss_act  = ~ss_s;
   assign s_rise  = sck_s & ~sck_d;
   assign s_fall  = ~sck_s & sck_d;
   assign rise    = cfg_q.master ? (m_tick & ~sck_q) : (ss_act & ~ovf_q & s_rise);
   assign fall    = cfg_q.master ? (m_tick &  sck_q) : (ss_act & ~ovf_q & s_fall);
   assign clr     = ~cfg_q.master & ~ss_act;
   assign start   = cfg_q.master & ~active_q & armed_q & ~ovf_q;
   assign load    = (~active_q & tx_full_q & ~armed_q) | (done & tx_full_q);
   assign rd_full = rx_full_q & ~buf_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q     <= '0;
         txbuf_q   <= '0;
         rxbuf_q   <= '0;
         tx_full_q <= 1'b0;
         rx_full_q <= 1'b0;
         ovf_q     <= 1'b0;
         flag_q    <= 1'b0;
         active_q  <= 1'b0;
         armed_q   <= 1'b0;
         sck_q     <= 1'b0;
         sck_d     <= 1'b0;
      end else begin
         sck_d <= sck_s;
         if (cfg_wr) cfg_q <= spi_cfg_t'(cfg_wdata);
         if (buf_wr) txbuf_q <= buf_wdata;

         if (buf_wr)    tx_full_q <= 1'b1;
         else if (load) tx_full_q <= 1'b0;

         if (load)                                     armed_q <= 1'b1;
         else if (done || start || (rise && !active_q)) armed_q <= 1'b0;

         if (done)              active_q <= 1'b0;
         else if (cfg_q.master) begin
            if (start) active_q <= 1'b1;
         end else if (!ss_act)  active_q <= 1'b0;
         else if (rise)         active_q <= 1'b1;

         if (!cfg_q.master || !active_q) sck_q <= 1'b0;
         else if (m_tick)                sck_q <= ~sck_q;

         if (done && !rd_full) rxbuf_q <= word;

         if (done && !rd_full) rx_full_q <= 1'b1;
         else if (buf_rd)      rx_full_q <= 1'b0;

         if (done && rd_full) ovf_q <= 1'b1;
         else if (buf_rd)     ovf_q <= 1'b0;

         if (done)          flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;
      end
   end

   assign buf_rdata  = rxbuf_q;
   assign st_rx_full = rx_full_q;
   assign st_tx_full = tx_full_q;
   assign st_ovf     = ovf_q;
   assign st_busy    = active_q;
   assign irq_flag   = flag_q;
   assign irq        = flag_q & cfg_q.ie;
   assign sck_o      = sck_q;
   assign sck_oe     = cfg_q.master;
   assign sdo        = obit;
   assign sdo_oe     = cfg_q.master | ss_act;

   // R3: new receive data always comes with the flag
   a_r3_flag_with_rx: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full_q) |-> flag_q);
   // R4: completion onto a full buffer raises overflow
   a_r4_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rx_full_q && !buf_rd) |=> ovf_q);
   // R5: frozen engine keeps the held word and its bit position
   a_r5_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !buf_rd) |=> $stable(rxbuf_q));
   a_r5_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> $stable(bit_cnt));
   // R7: tx full only rises from a processor write
   a_r7_tx_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_full_q) |-> $past(buf_wr));
   // R8: the master clock rests low whenever no word is in progress
   a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> !sck_q);
   // R11: a released select ends any slave word
   a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_q.master && ss_s) |=> !active_q);
endmodule

// File: tb/spi_dbuf_port_tb_top.sv
module spi_dbuf_port_tb_top;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n, cfg_wr, buf_wr, buf_rd, flag_clr, sck_i, ss_n, sdi, sdi_bench, loop_en;
   logic [7:0]  cfg_wdata;
   logic [15:0] buf_wdata, buf_rdata;
   logic        st_rx_full, st_tx_full, st_ovf, st_busy, irq_flag, irq, sck_o, sck_oe, sdo, sdo_oe;
   int          checks = 0, errors = 0;
   bit          finished = 0;

   assign sdi = loop_en ? sdo : sdi_bench;

   spi_dbuf_port dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_rd(buf_rd), .buf_rdata(buf_rdata),
      .flag_clr(flag_clr), .st_rx_full(st_rx_full), .st_tx_full(st_tx_full),
      .st_ovf(st_ovf), .st_busy(st_busy), .irq_flag(irq_flag), .irq(irq),
      .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .ss_n(ss_n), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic pulse_cfg(input logic [7:0] v);
      @(negedge clk); cfg_wdata = v; cfg_wr = 1'b1;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic cpu_wr(input logic [15:0] v);
      @(negedge clk); buf_wdata = v; buf_wr = 1'b1;
      @(negedge clk); buf_wr = 1'b0;
   endtask

   task automatic cpu_rd(output logic [15:0] v);
      @(negedge clk); v = buf_rdata; buf_rd = 1'b1;
      @(negedge clk); buf_rd = 1'b0;
   endtask

   task automatic clr_flag();
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
   endtask

   task automatic wait_rx();
      for (int i = 0; i < 40000 && !st_rx_full; i++) @(negedge clk);
   endtask

   task automatic wait_ovf();
      for (int i = 0; i < 40000 && !st_ovf; i++) @(negedge clk);
   endtask

   task automatic sck_rise_gap(output int n);
      logic pv;
      n = 0; pv = sck_o;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk); n++;
         if (sck_o && !pv) break;
         pv = sck_o;
      end
   endtask

   task automatic slave_xfer(input logic [15:0] mosi, input int nb, output logic [15:0] miso);
      miso = '0;
      for (int i = nb - 1; i >= 0; i--) begin
         @(negedge clk); sdi_bench = mosi[i];
         repeat (2) @(negedge clk); sck_i = 1'b1;
         repeat (8) @(negedge clk); miso[i] = sdo; sck_i = 1'b0;
         repeat (8) @(negedge clk);
      end
      repeat (6) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] v, miso, tx;
      int n;
      rst_n = 0; cfg_wr = 0; buf_wr = 0; buf_rd = 0; flag_clr = 0;
      sck_i = 0; ss_n = 1; sdi_bench = 0; loop_en = 1; cfg_wdata = 0; buf_wdata = 0;
      repeat (3) @(negedge clk); rst_n = 1;
      @(negedge clk);
      chk("R1 status", {st_rx_full, st_tx_full, st_ovf, st_busy, irq_flag, irq}, 0);
      chk("R1 sck_o/oe", {sck_o, sck_oe, sdo_oe}, 0);

      // master, 16 bit, fastest clock, irq enabled: 1000_0011
      pulse_cfg(8'h83);
      chk("R8 sck_oe master", sck_oe, 1);
      cpu_wr(16'hA5C3);
      wait_rx();
      chk("R2 16-bit loopback", buf_rdata, 16'hA5C3);
      chk("R3 flag and irq", {irq_flag, irq}, 2'b11);
      clr_flag();
      chk("R3 flag clear", {irq_flag, irq}, 0);
      cpu_rd(v);
      chk("R6 read clears rx full", st_rx_full, 0);

      // preload
      cpu_wr(16'h1234);
      cpu_wr(16'hBEEF);
      chk("R7 second word held", {st_tx_full, st_busy}, 2'b11);
      wait_rx();
      chk("R7 first word intact", buf_rdata, 16'h1234);
      chk("R7 preload clears tx full", st_tx_full, 0);
      cpu_rd(v);
      wait_rx();
      chk("R9 preloaded word sent", buf_rdata, 16'hBEEF);

      // master overflow: BEEF still unread
      cpu_wr(16'h0F0F);
      wait_ovf();
      chk("R4 overflow set", st_ovf, 1);
      chk("R4 old word kept", buf_rdata, 16'hBEEF);
      cpu_wr(16'h7E81);
      repeat (200) @(negedge clk);
      chk("R5 no start while frozen", {st_busy, sck_o}, 0);
      cpu_rd(v);
      chk("R6 read returns held word", v, 16'hBEEF);
      chk("R6 read clears overflow", st_ovf, 0);
      wait_rx();
      chk("R9 resumes after read", buf_rdata, 16'h7E81);
      cpu_rd(v);

      // enable off: flag only
      pulse_cfg(8'h03);
      cpu_wr(16'h00AA);
      wait_rx();
      chk("R3 irq gated by enable", {irq_flag, irq}, 2'b10);
      cpu_rd(v);
      clr_flag();

      // divider sweep, 8-bit mode
      for (int sel = 0; sel < 4; sel++) begin
         for (int s = 1; s <= 8; s++) begin
            pulse_cfg({1'b0, 3'(s - 1), 2'(sel), 1'b0, 1'b1});
            tx = {8'hC3, 8'((sel * 8 + s) * 29)};
            cpu_wr(tx);
            sck_rise_gap(n);
            sck_rise_gap(n);
            chk($sformatf("R8 period sel=%0d s=%0d", sel, s), n, 2 * (1 << (2 * sel)) * s);
            wait_rx();
            chk("R2 8-bit loopback", buf_rdata, {8'h00, tx[7:0]});
            cpu_rd(v);
         end
      end

      // slave, 16 bit, ie on: 1000_0010
      loop_en = 0;
      pulse_cfg(8'h82);
      clr_flag();
      chk("R10 sdo_oe off when deselected", sdo_oe, 0);
      cpu_wr(16'h5A3C);
      repeat (3) @(negedge clk);
      ss_n = 0;
      repeat (4) @(negedge clk);
      chk("R10 sdo_oe on when selected", sdo_oe, 1);
      slave_xfer(16'hB1E7, 16, miso);
      chk("R10 slave sends tx word", miso, 16'h5A3C);
      chk("R10 slave receives word", buf_rdata, 16'hB1E7);
      cpu_rd(v);
      ss_n = 1;

      // slave 8 bit
      pulse_cfg(8'h80);
      cpu_wr(16'h4496);
      repeat (3) @(negedge clk); ss_n = 0; repeat (4) @(negedge clk);
      slave_xfer(16'h004D, 8, miso);
      chk("R2 slave 8-bit out", miso[7:0], 8'h96);
      chk("R2 slave 8-bit in", buf_rdata, 16'h004D);
      cpu_rd(v);
      clr_flag();

      // abort mid word
      slave_xfer(16'h000F, 4, miso);
      ss_n = 1;
      repeat (6) @(negedge clk);
      chk("R11 sdo_oe off after release", sdo_oe, 0);
      chk("R11 partial word not completed", {irq_flag, st_rx_full}, 0);
      ss_n = 0; repeat (4) @(negedge clk);
      slave_xfer(16'h003B, 8, miso);
      chk("R11 counter restarted", buf_rdata, 16'h003B);

      // slave overflow, 3B unread
      slave_xfer(16'h0077, 8, miso);
      chk("R4 slave overflow", st_ovf, 1);
      chk("R4 slave old word kept", buf_rdata, 16'h003B);
      clr_flag();
      slave_xfer(16'h0011, 8, miso);
      chk("R5 edges ignored when frozen", {irq_flag, st_ovf}, 2'b01);
      chk("R5 held word unchanged", buf_rdata, 16'h003B);
      cpu_rd(v);
      chk("R6 slave read clears", {st_ovf, st_rx_full}, 0);
      ss_n = 1;

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule